// File: doc/BRIEF.md
# Cascadable Configuration Image Reader

This block is the read side of a one-time-programmable store. It holds a configuration image and streams it, in address order, to a downstream loader that supplies the clock. An internal byte array holds the image. In use the array is fixed; a synchronous write port fills it during test. An address counter moves through the image on rising clock edges. The output is either one bit per clock on the lowest data line, or one full byte per clock on all eight lines.

Three controls decide whether the counter may move. The first is an active-low chip enable. The second is a combined reset/output-enable pin whose polarity is set by a parameter. The third is a hold input that freezes the stream partway through. When the counter steps past the last address of the image, the active-low cascade output goes low. That output drives the chip enable of the next device, so several devices can be chained to hold one long image.

Tri-state is not modelled with an inout bus. A separate output-enable signal states when the data lines would be driven.

Top module: `cfg_rom_reader`

## Requirements
- R1: The address counter advances on a rising clock edge only when chip enable is active (`chip_en_n` low), the reset/output-enable pin is in its enable state, and `hold` is low.
- R2: While the reset/output-enable pin is in its reset state, the counter is held at address 0 (bit 7 in serial mode), `dout_oe` is 0 and `cas_en_n` is 1.
- R3: With `RST_ACTIVE_HIGH`=1 the pin resets when high. With `RST_ACTIVE_HIGH`=0 it resets when low.
- R4: While `chip_en_n` is high, the counter keeps its value, `dout_oe` is 0 and `standby` is 1. When chip enable returns, the stream resumes at the same position.
- R5: `cas_en_n` is 0 only when chip enable is active, the pin is in its enable state, and the counter has stepped past address `TC`. After that it follows `chip_en_n` for as long as the pin stays enabled.
- R6: While `hold` is 1, the position and `dout` keep their values. When `hold` returns to 0, the stream continues from the held position.
- R7: With `par_mode`=1, `dout[7:0]` carries the whole byte at the current address, and each advancing edge moves to the next byte. The new value is visible after that edge, with no further cycle of latency.
- R8: With `par_mode`=0, `dout[0]` carries one bit of the current byte, most significant bit first, and `dout[7:1]` is 0. The byte address advances on every eighth advancing edge.
- R9: When the counter steps past address `TC`, it stays at `TC` and does not wrap. `dout` keeps showing the byte at `TC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the loader |
| chip_en_n | input | 1 | Chip enable, active low |
| rstoe_pin | input | 1 | Combined reset/output enable; polarity set by `RST_ACTIVE_HIGH` |
| hold | input | 1 | Freezes the position and the output while high |
| par_mode | input | 1 | 1 = byte per clock, 0 = bit per clock on `dout[0]` |
| wr_en | input | 1 | Test write strobe for the image array |
| wr_addr | input | AW | Test write byte address |
| wr_data | input | 8 | Test write byte |
| dout | output | 8 | Image data |
| dout_oe | output | 1 | 1 when the data lines are driven, 0 for high impedance |
| cas_en_n | output | 1 | Cascade enable to the next device, active low |
| standby | output | 1 | Low-power standby indication (chip enable inactive) |

## Verification
The bench builds the main instance with a six-byte image (`DEPTH`=6, `TC`=5) and an active-low reset pin. The short image means the terminal count handoff, saturation and the return of the cascade output all come up in a few dozen cycles of byte-wide streaming. A second instance uses the default active-high polarity, and its pin is driven with the inverse of the first instance's pin. Both must then behave the same, which checks the polarity option against the same expected stream.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = 3;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BIT_W-1:0]  bitidx_t;
endpackage

// File: rtl/cfg_rom_array.sv
module cfg_rom_array
    import cfg_rom_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);
    byte_t mem_q [DEPTH];

    // Test-only fill port; the read path is combinational from the address.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = mem_q[rd_addr];
    end
endmodule

// File: rtl/cfg_rom_pins.sv
module cfg_rom_pins #(
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic rstoe_pin,
    input  logic chip_en_n,
    output logic rst_act,
    output logic ce_act
);
    generate
        if (RST_ACTIVE_HIGH) begin : g_pol_high
            assign rst_act = rstoe_pin;
        end else begin : g_pol_low
            assign rst_act = ~rstoe_pin;
        end
    endgenerate

    assign ce_act = ~chip_en_n;
endmodule

// File: rtl/cfg_rom_seq.sv
module cfg_rom_seq
    import cfg_rom_pkg::*;
#(
    parameter int AW = 8,
    parameter int TC = 255
) (
    input  logic          clk,
    input  logic          rst_i,
    input  logic          adv_i,
    input  logic          par_i,
    output logic [AW-1:0] addr_o,
    output bitidx_t       bit_o,
    output logic          done_o
);
    localparam logic [AW-1:0] TC_A = AW'(TC);

    typedef struct packed {
        logic [AW-1:0] addr;
        bitidx_t       bit_idx;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;
    logic last_unit;

    always_comb begin
        st_d      = st_q;
        last_unit = par_i || (st_q.bit_idx == bitidx_t'(BYTE_W - 1));
        if (adv_i && !st_q.done) begin
            if (last_unit) begin
                st_d.bit_idx = '0;
                if (st_q.addr == TC_A) begin
                    st_d.done = 1'b1;      // stepped past the end: saturate
                end else begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end else begin
                st_d.bit_idx = st_q.bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign bit_o  = st_q.bit_idx;
    assign done_o = st_q.done;
endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader
    import cfg_rom_pkg::*;
#(
    parameter int DEPTH           = 256,
    parameter int TC              = DEPTH - 1,
    parameter bit RST_ACTIVE_HIGH = 1'b1,
    localparam int AW             = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          chip_en_n,
    input  logic          rstoe_pin,
    input  logic          hold,
    input  logic          par_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    dout,
    output logic          dout_oe,
    output logic          cas_en_n,
    output logic          standby
);
    logic          rst_act;
    logic          ce_act;
    logic          adv;
    logic [AW-1:0] cur_addr;
    bitidx_t       cur_bit;
    logic          past_tc;
    byte_t         rd_byte;

    cfg_rom_pins #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) pins_i (
        .rstoe_pin (rstoe_pin),
        .chip_en_n (chip_en_n),
        .rst_act   (rst_act),
        .ce_act    (ce_act)
    );

    assign adv = ce_act && !rst_act && !hold;

    cfg_rom_seq #(.AW(AW), .TC(TC)) seq_i (
        .clk    (clk),
        .rst_i  (rst_act),
        .adv_i  (adv),
        .par_i  (par_mode),
        .addr_o (cur_addr),
        .bit_o  (cur_bit),
        .done_o (past_tc)
    );

    cfg_rom_array #(.DEPTH(DEPTH), .AW(AW)) array_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_data (rd_byte)
    );

    always_comb begin
        if (par_mode) begin
            dout = rd_byte;
        end else begin
            dout = {7'b0, rd_byte[3'd7 - cur_bit]};
        end
    end

    assign dout_oe  = ce_act && !rst_act;
    assign standby  = !ce_act;
    assign cas_en_n = !(ce_act && !rst_act && past_tc);
endmodule

// File: rtl/cfg_rom_reader_chk.sv
module cfg_rom_reader_chk #(
    parameter int AW = 8,
    parameter int TC = 255
) (
    input logic          clk,
    input logic          rst_act,
    input logic          ce_act,
    input logic          hold,
    input logic          dout_oe,
    input logic          standby,
    input logic          cas_en_n,
    input logic [AW-1:0] cur_addr,
    input logic [2:0]    cur_bit
);
    localparam logic [AW-1:0] TC_A = AW'(TC);

    assert_rst_quiet_R2: assert property (@(posedge clk)
        rst_act |-> (!dout_oe && cas_en_n && cur_addr == '0));

    assert_standby_R4: assert property (@(posedge clk)
        !ce_act |-> (standby && !dout_oe));

    assert_casc_gate_R5: assert property (@(posedge clk)
        !cas_en_n |-> (ce_act && !rst_act));

    assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst_act)
        hold |=> ($stable(cur_addr) && $stable(cur_bit)));

    assert_ce_freeze_R4: assert property (@(posedge clk) disable iff (rst_act)
        !ce_act |=> $stable(cur_addr));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst_act)
        (cur_addr == TC_A) |=> (cur_addr == TC_A));
endmodule

bind cfg_rom_reader cfg_rom_reader_chk #(.AW(AW), .TC(TC)) chk_i (
    .clk      (clk),
    .rst_act  (rst_act),
    .ce_act   (ce_act),
    .hold     (hold),
    .dout_oe  (dout_oe),
    .standby  (standby),
    .cas_en_n (cas_en_n),
    .cur_addr (cur_addr),
    .cur_bit  (cur_bit)
);

// File: tb/cfg_rom_reader_tb_top.sv
module cfg_rom_reader_tb_top;
    localparam int DEPTH = 6;
    localparam int TC    = 5;
    localparam int AW    = 3;

    typedef struct {
        string      tag;
        bit         chk_d;
        logic [7:0] d;
        logic       oe;
        logic       ceo_n;
        logic       sb;
    } exp_t;

    logic          clk = 1'b0;
    logic          chip_en_n = 1'b0;
    logic          rstn_pin = 1'b0;
    logic          hold = 1'b0;
    logic          par_mode = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    dout, dout_h;
    logic          dout_oe, dout_oe_h, cas_en_n, cas_en_n_h, standby, standby_h;

    int   n_run  = 0;
    int   n_fail = 0;
    exp_t sb_q[$];
    bit   all_done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_rom_reader #(.DEPTH(DEPTH), .TC(TC), .RST_ACTIVE_HIGH(1'b0)) dut_i (
        .clk(clk), .chip_en_n(chip_en_n), .rstoe_pin(rstn_pin), .hold(hold),
        .par_mode(par_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout), .dout_oe(dout_oe), .cas_en_n(cas_en_n), .standby(standby)
    );

    // Default polarity; pin driven inverted so it must track dut_i exactly (R3).
    cfg_rom_reader #(.DEPTH(DEPTH), .TC(TC)) dut_hi (
        .clk(clk), .chip_en_n(chip_en_n), .rstoe_pin(~rstn_pin), .hold(hold),
        .par_mode(par_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout_h), .dout_oe(dout_oe_h), .cas_en_n(cas_en_n_h), .standby(standby_h)
    );

    function automatic logic [7:0] img(int i);
        return 8'(8'hC3 + i * 8'h4D);
    endfunction

    task automatic check1(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(string tag, bit chk_d, logic [7:0] d, logic oe, logic ceo_n, logic sb);
        exp_t e;
        e.tag = tag; e.chk_d = chk_d; e.d = d; e.oe = oe; e.ceo_n = ceo_n; e.sb = sb;
        sb_q.push_back(e);
    endtask

    // Monitor: compares both instances against each queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check1(e.tag, "dout_oe", {7'b0, dout_oe}, {7'b0, e.oe});
                check1(e.tag, "cas_en_n", {7'b0, cas_en_n}, {7'b0, e.ceo_n});
                check1(e.tag, "standby", {7'b0, standby}, {7'b0, e.sb});
                check1({e.tag, " R3"}, "pol dout_oe", {7'b0, dout_oe_h}, {7'b0, e.oe});
                check1({e.tag, " R3"}, "pol cas_en_n", {7'b0, cas_en_n_h}, {7'b0, e.ceo_n});
                if (e.chk_d) begin
                    check1(e.tag, "dout", dout, e.d);
                    check1({e.tag, " R3"}, "pol dout", dout_h, e.d);
                end
            end
        end
    end

    initial begin
        // Fill the image while held in reset.
        for (int i = 0; i < DEPTH; i++) begin
            tick();
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = img(i);
        end
        tick(); wr_en = 1'b0;
        push("R2 reset", 0, 8'h00, 0, 1, 0);

        // Byte-wide stream through terminal count.
        tick(); rstn_pin = 1'b1;
        push("R7 first byte", 1, img(0), 1, 1, 0);
        for (int i = 1; i <= TC; i++) begin
            tick(); push("R1 R7 stream", 1, img(i), 1, 1, 0);
        end
        tick(); push("R5 past tc", 1, img(TC), 1, 0, 0);
        tick(); push("R9 saturate", 1, img(TC), 1, 0, 0);

        // Cascade output follows chip enable.
        tick(); chip_en_n = 1'b1; push("R4 R5 ce off", 0, 8'h00, 0, 1, 1);
        tick(); chip_en_n = 1'b0; push("R5 R9 ce back", 1, img(TC), 1, 0, 0);

        // Reset pulse clears position and cascade output.
        tick(); rstn_pin = 1'b0; push("R2 reset pulse", 0, 8'h00, 0, 1, 0);
        tick(); rstn_pin = 1'b1; push("R2 restart", 1, img(0), 1, 1, 0);

        // Hold freezes the stream.
        tick(); push("R1 step", 1, img(1), 1, 1, 0);
        tick(); hold = 1'b1; push("R6 pre-hold", 1, img(2), 1, 1, 0);
        tick(); push("R6 held", 1, img(2), 1, 1, 0);
        tick(); push("R6 held", 1, img(2), 1, 1, 0);
        tick(); hold = 1'b0; push("R6 release", 1, img(2), 1, 1, 0);
        tick(); push("R6 resume", 1, img(3), 1, 1, 0);

        // Chip enable off freezes position.
        tick(); chip_en_n = 1'b1; push("R4 standby", 0, 8'h00, 0, 1, 1);
        tick(); push("R4 standby", 0, 8'h00, 0, 1, 1);
        tick(); chip_en_n = 1'b0; push("R4 resume", 1, img(4), 1, 1, 0);
        tick(); push("R4 next", 1, img(5), 1, 1, 0);

        // Serial mode, MSB first.
        tick(); rstn_pin = 1'b0; par_mode = 1'b0; push("R2 serial reset", 0, 8'h00, 0, 1, 0);
        tick(); rstn_pin = 1'b1;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] b;
            if (k > 0) tick();
            b = img(k / 8);
            push("R8 serial bit", 1, {7'b0, b[7 - (k % 8)]}, 1, 1, 0);
        end
        tick(); tick();
        all_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!all_done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!all_done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule